// File: doc/BRIEF.md
# Real-Time-Clock Alarm Comparator with Repeat Selection

This block watches a BCD time of day supplied by an external calendar counter and raises an alarm when that time matches a programmed alarm setting. Software programs four byte-wide alarm registers through a simple write port: seconds, minutes, hours and day of month. Bit 7 of each alarm register is a "don't care" mask bit. Taken together, the four mask bits select how often the alarm repeats: monthly, daily, hourly, once a minute or every second.

The comparison runs only in the cycle where the one-second tick input is high, so each qualifying second produces at most one alarm. An alarm sets a sticky status flag. If the interrupt-enable bit is set, the alarm also produces a one-cycle interrupt pulse. The block checks every write to an alarm register and silently drops a value whose BCD field is malformed or out of range. A read of the status register clears the flag.

Top module: `rtc_alarm_match`

## Requirements
- R1: Register map on `addr`: 0 alarm seconds, 1 alarm minutes, 2 alarm hours, 3 alarm date, 4 control (bit 0 = interrupt enable), 5 status (bit 0 = alarm flag, read-only, writes ignored). Addresses 6 and 7 read as zero. An alarm register reads back the whole stored byte, including its mask in bit 7. After reset, every register, `irq` and `alarm_flag` are zero.
- R2: A write to seconds or minutes is kept only if bits 6:4 (tens) and 3:0 (units) form a valid BCD value, with units at most 9 and the value at most 59. Otherwise the register keeps its old value.
- R3: A write to hours is kept only if bits 5:4 (tens) and 3:0 (units) form BCD 0 to 23 with units at most 9. Otherwise it is dropped.
- R4: A write to the date is kept only if bits 5:4 (tens) and 3:0 (units) form BCD 1 to 31 with units at most 9. Otherwise it is dropped.
- R5: The match is evaluated only in a cycle with `tick` high. With `tick` low, no alarm occurs, whatever the time inputs are.
- R6: With all four masks clear, an alarm occurs when the date, hour, minute and second all equal the programmed values.
- R7: With only the date mask set, an alarm occurs when the hour, minute and second match.
- R8: With only the date and hour masks set, an alarm occurs when the minute and second match.
- R9: With the date, hour and minute masks set and the seconds mask clear, an alarm occurs when the second matches.
- R10: Every other mask combination raises an alarm on every tick.
- R11: When interrupts are enabled, an alarm drives `irq` high for exactly one cycle, the cycle after the tick. When they are disabled, `irq` stays low.
- R12: An alarm sets `alarm_flag` whether or not interrupts are enabled. The flag stays set until a cycle with `rd_en` high at address 5. In that cycle `rdata` still shows the flag, and it clears at the following edge. If an alarm occurs in the same cycle as such a read, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe once per second |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_date | input | 6 | Current day of month, BCD |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on status) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | One-cycle alarm interrupt pulse |
| alarm_flag | output | 1 | Sticky alarm status |

## Verification
A stored alarm byte that is wrong, whether from a dropped write that was accepted or a valid one that was rejected, shows up right away on `rdata` at the next read of that address. A wrong mask bit instead changes the repeat mode, so the alarm fires or stays silent on the very next tick for the time patterns that differ in a single field. A flag or enable bit stuck in the wrong state shows on `alarm_flag` or `irq` in the cycle after a tick, and on the status read that follows. Because of this, every pattern is checked one cycle after its tick and again after its clearing read.

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [6:0] cur_sec,
  input  logic [6:0] cur_min,
  input  logic [5:0] cur_hour,
  input  logic [5:0] cur_date,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       alarm_flag
);
  localparam logic [2:0] A_SEC  = 3'd0;
  localparam logic [2:0] A_MIN  = 3'd1;
  localparam logic [2:0] A_HOUR = 3'd2;
  localparam logic [2:0] A_DATE = 3'd3;
  localparam logic [2:0] A_CTRL = 3'd4;
  localparam logic [2:0] A_STAT = 3'd5;

  logic [7:0] al_sec, al_min, al_hour, al_date;
  logic       irq_en, flag_q, irq_q;
  logic       hit;

  function automatic logic bcd_in_range(input logic [2:0] tens, input logic [3:0] units,
                                        input int lo, input int hi);
    int n;
    n = int'(tens) * 10 + int'(units);
    return (units <= 4'd9) && (n >= lo) && (n <= hi);
  endfunction

  wire sec_ok  = bcd_in_range(wdata[6:4], wdata[3:0], 0, 59);
  wire hour_ok = bcd_in_range({1'b0, wdata[5:4]}, wdata[3:0], 0, 23);
  wire date_ok = bcd_in_range({1'b0, wdata[5:4]}, wdata[3:0], 1, 31);

  wire [3:0] mask = {al_date[7], al_hour[7], al_min[7], al_sec[7]};
  wire eq_s = (cur_sec  == al_sec[6:0]);
  wire eq_m = (cur_min  == al_min[6:0]);
  wire eq_h = (cur_hour == al_hour[5:0]);
  wire eq_d = (cur_date == al_date[5:0]);

  always_comb begin
    case (mask)
      4'b0000: hit = eq_d & eq_h & eq_m & eq_s;
      4'b1000: hit = eq_h & eq_m & eq_s;
      4'b1100: hit = eq_m & eq_s;
      4'b1110: hit = eq_s;
      default: hit = 1'b1;
    endcase
  end

  wire fire = tick & hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_sec  <= '0;
      al_min  <= '0;
      al_hour <= '0;
      al_date <= '0;
      irq_en  <= 1'b0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_SEC:   if (sec_ok)  al_sec  <= wdata;
          A_MIN:   if (sec_ok)  al_min  <= wdata;
          A_HOUR:  if (hour_ok) al_hour <= wdata;
          A_DATE:  if (date_ok) al_date <= wdata;
          A_CTRL:  irq_en <= wdata[0];
          default: ;
        endcase
      end
      if (fire)
        flag_q <= 1'b1;
      else if (rd_en && addr == A_STAT)
        flag_q <= 1'b0;
      irq_q <= fire & irq_en;
    end
  end

  always_comb begin
    case (addr)
      A_SEC:   rdata = al_sec;
      A_MIN:   rdata = al_min;
      A_HOUR:  rdata = al_hour;
      A_DATE:  rdata = al_date;
      A_CTRL:  rdata = {7'd0, irq_en};
      A_STAT:  rdata = {7'd0, flag_q};
      default: rdata = 8'd0;
    endcase
  end

  assign irq        = irq_q;
  assign alarm_flag = flag_q;
endmodule

// File: rtl/rtc_alarm_match_chk.sv
`timescale 1ns/1ps
module rtc_alarm_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic       rd_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic       irq,
  input logic       alarm_flag,
  input logic       irq_en,
  input logic [7:0] al_sec
);
  wire sec_bad = (wdata[3:0] > 4'd9) || (wdata[6:4] > 3'd5);

  assert_no_irq_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !irq);

  assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(tick) && $past(irq_en)));

  assert_irq_implies_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> alarm_flag);

  assert_status_read_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd5 && !tick) |=> !alarm_flag);

  assert_bad_sec_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && sec_bad) |=> $stable(al_sec));
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .irq(irq), .alarm_flag(alarm_flag),
  .irq_en(irq_en), .al_sec(al_sec)
);

// File: tb/tb_rtc_alarm_match.sv
`timescale 1ns/1ps
module tb_rtc_alarm_match;
  logic       clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [6:0] cur_sec = 0, cur_min = 0;
  logic [5:0] cur_hour = 0, cur_date = 0;
  wire  [7:0] rdata;
  wire        irq, alarm_flag;

  int checks = 0, fails = 0;
  logic [7:0] model [4];
  logic [7:0] d;

  rtc_alarm_match dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk); addr = a; wdata = v; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic rd_status(output logic [7:0] v);
    @(negedge clk); addr = 3'd5; rd_en = 1; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  function automatic bit valid(input int r, input logic [7:0] v);
    int t, u, n;
    u = int'(v[3:0]);
    t = (r < 2) ? int'(v[6:4]) : int'(v[5:4]);
    n = t * 10 + u;
    if (u > 9) return 0;
    if (r < 2) return n <= 59;
    if (r == 2) return n <= 23;
    return (n >= 1) && (n <= 31);
  endfunction

  function automatic bit expect_fire(input int m, input bit ed, input bit eh, input bit em, input bit es);
    case (m)
      0:  return ed && eh && em && es;
      8:  return eh && em && es;
      12: return em && es;
      14: return es;
      default: return 1;
    endcase
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R6"; 8: return "R7"; 12: return "R8"; 14: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1 check("R1 reset regs", rdata, 0);
    end
    check("R1 reset irq", irq, 0);
    check("R1 reset flag", alarm_flag, 0);
    @(negedge clk); rst_n = 1;

    for (int r = 0; r < 4; r++) begin
      for (int v = 0; v < 256; v++) begin
        wr(3'(r), 8'(v));
        if (valid(r, 8'(v))) model[r] = 8'(v);
        rd(3'(r), d);
        check(r < 2 ? "R2 sec/min write filter" : (r == 2 ? "R3 hour write filter" : "R4 date write filter"),
              d, model[r]);
      end
    end
    check("R5 no tick no flag", alarm_flag, 0);
    check("R5 no tick no irq", irq, 0);

    wr(3'd4, 8'h01);
    rd(3'd4, d); check("R1 control readback", d, 1);
    wr(3'd5, 8'hFF);
    rd(3'd5, d); check("R1 status write ignored", d, 0);
    rd(3'd6, d); check("R1 unused addr", d, 0);

    for (int m = 0; m < 16; m++) begin
      wr(3'd0, 8'h30 | (m[0] ? 8'h80 : 8'h00));
      wr(3'd1, 8'h45 | (m[1] ? 8'h80 : 8'h00));
      wr(3'd2, 8'h13 | (m[2] ? 8'h80 : 8'h00));
      wr(3'd3, 8'h21 | (m[3] ? 8'h80 : 8'h00));
      for (int p = 0; p < 5; p++) begin
        bit ex;
        cur_date = (p == 1) ? 6'h22 : 6'h21;
        cur_hour = (p == 2) ? 6'h14 : 6'h13;
        cur_min  = (p == 3) ? 7'h46 : 7'h45;
        cur_sec  = (p == 4) ? 7'h31 : 7'h30;
        ex = expect_fire(m, p != 1, p != 2, p != 3, p != 4);
        pulse_tick();
        check({mode_tag(m), " irq after tick"}, irq, ex);
        check({mode_tag(m), " flag set"}, alarm_flag, ex);
        @(negedge clk);
        check("R11 irq single cycle", irq, 0);
        rd_status(d);
        check("R12 status read shows flag", d, ex);
        check("R12 flag cleared by read", alarm_flag, 0);
      end
    end

    wr(3'd0, 8'h30); wr(3'd1, 8'h45); wr(3'd2, 8'h13); wr(3'd3, 8'h21);
    cur_date = 6'h21; cur_hour = 6'h13; cur_min = 7'h45; cur_sec = 7'h30;
    repeat (6) @(negedge clk);
    check("R5 match without tick irq", irq, 0);
    check("R5 match without tick flag", alarm_flag, 0);

    wr(3'd4, 8'h00);
    pulse_tick();
    check("R11 disabled irq", irq, 0);
    check("R12 flag sets while disabled", alarm_flag, 1);

    @(negedge clk); addr = 3'd5; rd_en = 1; tick = 1;
    @(negedge clk); rd_en = 0; tick = 0;
    check("R12 alarm wins over clearing read", alarm_flag, 1);
    rd_status(d);
    check("R12 status read", d, 1);
    check("R12 cleared after read", alarm_flag, 0);

    finish_run();
  end
endmodule